// File: doc/BRIEF.md
# Duplicate-and-Compare Self-Checking 4-Bit Adder

This block computes a W-bit sum with carry-in and carry-out (W = 4 by default, so 9 inputs and 5 outputs). Two independent gate-level ripple adders evaluate the same operands, and the two copies share no logic. The primary result comes from copy A. Each output bit of copy A is paired with the inverted matching bit of copy B, so every pair is complementary when the two bits agree. A chain of two-rail checker cells folds these pairs into one error pair. The checker cells take two pairs at a time and produce a complementary output only when both inputs are complementary.

The result and the error pair are captured on one rising clock edge. The error pair reads 01 or 10 when no error is present and 00 or 11 when one is detected. A consumer acts on the result only when the pair is complementary. A fault-injection port forces one internal net to a chosen constant. Each adder net, each inverted copy-B bit and each checker-cell output has its own index, so that single stuck-at behaviour can be exercised from the bench.

Top module: `sc_dup_adder`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `sum_q` = 0, `cout_q` = 0 and `err_rail` = 2'b01.
- R2: With no fault injected, `{cout_q, sum_q}` equals `a + b + cin` of the inputs sampled at the preceding rising edge.
- R3: With no fault injected, `err_rail` is 2'b01 or 2'b10 for every input combination.
- R4: With any single stuck-at net forced, a registered result that differs from `a + b + cin` is always accompanied by `err_rail` of 2'b00 or 2'b11.
- R5: For every injectable net and each stuck value, at least one input combination drives `err_rail` to 2'b00 or 2'b11.
- R6: Net indices are 0 to 5W-1 for copy A, 5W to 10W-1 for copy B, 10W to 11W for the inverted copy-B bits, and the two-rail cell outputs follow, giving 53 nets at W = 4. A `flt_sel` of all ones, or any index past the last net, injects nothing, and the block then behaves as in R2 and R3.
- R7: A fault on any net outside copy A (index 5W or above) never changes `{cout_q, sum_q}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry-in |
| flt_sel | input | FSEL_W | Index of the net to force; all ones means no fault |
| flt_val | input | 1 | Constant forced onto the selected net |
| sum_q | output | W | Registered sum from copy A |
| cout_q | output | 1 | Registered carry-out from copy A |
| err_rail | output | 2 | Registered two-rail error pair: 01/10 no error, 00/11 error |

## Verification
All 512 operand and carry-in combinations are applied fault-free. This shows that the arithmetic is right and that the checker never raises a false alarm. The same full sweep is then repeated for every net index with each stuck value. It separates three outcomes: a silent wrong sum, which is forbidden; a masked fault; and a detected fault. It also confirms that every fault is caught at least once. Seeded random operands with random fault indices, including indices beyond the net range, and the directed extremes 0+0+0 and 15+15+1 cover the disable rule and the full carry chain.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned NETS_PER_BIT = 5;

  // Returns the forced value when this net is the selected one.
  function automatic logic stuck(input logic v, input int unsigned here,
                                 input int unsigned sel, input logic fv);
    return (sel == here) ? fv : v;
  endfunction

  // Golden sum for widths up to 16 bits.
  function automatic logic [16:0] add_ref(input logic [15:0] x, input logic [15:0] y,
                                          input logic c);
    return 17'(x) + 17'(y) + 17'(c);
  endfunction
endpackage

// File: rtl/sc_rca.sv
module sc_rca #(
  parameter int unsigned W      = 4,
  parameter int unsigned BASE   = 0,
  parameter int unsigned FSEL_W = 6
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic              cin,
  input  logic [FSEL_W-1:0] fsel,
  input  logic              fval,
  output logic [W:0]        res
);
  logic [W:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam int unsigned IX = BASE + sc_pkg::NETS_PER_BIT * i;
    logic p, g, s, t;
    assign p        = sc_pkg::stuck(a[i] ^ b[i], IX,     32'(fsel), fval);
    assign g        = sc_pkg::stuck(a[i] & b[i], IX + 1, 32'(fsel), fval);
    assign s        = sc_pkg::stuck(p ^ c[i],    IX + 2, 32'(fsel), fval);
    assign t        = sc_pkg::stuck(p & c[i],    IX + 3, 32'(fsel), fval);
    assign c[i+1]   = sc_pkg::stuck(g | t,       IX + 4, 32'(fsel), fval);
    assign res[i]   = s;
  end

  assign res[W] = c[W];
endmodule

// File: rtl/sc_trc.sv
module sc_trc #(
  parameter int unsigned BASE   = 0,
  parameter int unsigned FSEL_W = 6
) (
  input  logic [1:0]        x,
  input  logic [1:0]        y,
  input  logic [FSEL_W-1:0] fsel,
  input  logic              fval,
  output logic [1:0]        z
);
  assign z[0] = sc_pkg::stuck((x[0] & y[0]) | (x[1] & y[1]), BASE,     32'(fsel), fval);
  assign z[1] = sc_pkg::stuck((x[0] & y[1]) | (x[1] & y[0]), BASE + 1, 32'(fsel), fval);
endmodule

// File: rtl/sc_dup_adder.sv
module sc_dup_adder #(
  parameter int unsigned W      = 4,
  parameter int unsigned FSEL_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic              cin,
  input  logic [FSEL_W-1:0] flt_sel,
  input  logic              flt_val,
  output logic [W-1:0]      sum_q,
  output logic              cout_q,
  output logic [1:0]        err_rail
);
  localparam int unsigned NO        = W + 1;
  localparam int unsigned COPY_NETS = sc_pkg::NETS_PER_BIT * W;
  localparam int unsigned B_BASE    = COPY_NETS;
  localparam int unsigned INV_BASE  = 2 * COPY_NETS;
  localparam int unsigned CELL_BASE = INV_BASE + NO;

  logic [W:0] res_a, res_b;
  logic [1:0] pr  [NO];
  logic [1:0] acc [NO];
  logic [1:0] err_d;

  sc_rca #(.W(W), .BASE(0), .FSEL_W(FSEL_W)) u_copy_a (
    .a(a), .b(b), .cin(cin), .fsel(flt_sel), .fval(flt_val), .res(res_a));

  sc_rca #(.W(W), .BASE(B_BASE), .FSEL_W(FSEL_W)) u_copy_b (
    .a(a), .b(b), .cin(cin), .fsel(flt_sel), .fval(flt_val), .res(res_b));

  // Pair each copy-A bit with the inverted copy-B bit: agreement gives a code word.
  for (genvar i = 0; i < NO; i++) begin : g_pair
    assign pr[i][0] = res_a[i];
    assign pr[i][1] = sc_pkg::stuck(~res_b[i], INV_BASE + i, 32'(flt_sel), flt_val);
  end

  assign acc[0] = pr[0];
  for (genvar k = 1; k < NO; k++) begin : g_chain
    sc_trc #(.BASE(CELL_BASE + 2 * (k - 1)), .FSEL_W(FSEL_W)) u_cell (
      .x(acc[k-1]), .y(pr[k]), .fsel(flt_sel), .fval(flt_val), .z(acc[k]));
  end

  assign err_d = acc[NO-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q    <= '0;
      cout_q   <= 1'b0;
      err_rail <= 2'b01;
    end else begin
      sum_q    <= res_a[W-1:0];
      cout_q   <= res_a[W];
      err_rail <= err_d;
    end
  end
endmodule

// File: rtl/sc_dup_adder_chk.sv
module sc_dup_adder_chk #(
  parameter int unsigned W      = 4,
  parameter int unsigned FSEL_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [W-1:0]      a,
  input logic [W-1:0]      b,
  input logic              cin,
  input logic [FSEL_W-1:0] flt_sel,
  input logic [W-1:0]      sum_q,
  input logic              cout_q,
  input logic [1:0]        err_rail,
  input logic [W:0]        res_b
);
  localparam int unsigned B_BASE = sc_pkg::NETS_PER_BIT * W;
  localparam int unsigned NETS   = 10 * W + 3 * (W + 1) - 2;

  logic [16:0] gold;
  logic        no_fault, outside_a;
  assign gold      = sc_pkg::add_ref(16'(a), 16'(b), cin);
  assign no_fault  = 32'(flt_sel) >= NETS;
  assign outside_a = 32'(flt_sel) >= B_BASE;

  p_reset_pair_r1: assert property (@(posedge clk)
    rst |=> (err_rail == 2'b01 && sum_q == '0 && cout_q == 1'b0));

  p_sum_ok_r2: assert property (@(posedge clk) disable iff (rst)
    no_fault |=> ({cout_q, sum_q} == $past(gold[W:0])));

  p_code_clean_r3: assert property (@(posedge clk) disable iff (rst)
    no_fault |=> (err_rail[0] != err_rail[1]));

  p_secure_r4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((err_rail[0] == err_rail[1]) || ({cout_q, sum_q} == $past(gold[W:0]))));

  p_primary_safe_r7: assert property (@(posedge clk) disable iff (rst)
    outside_a |=> ({cout_q, sum_q} == $past(gold[W:0])));

  // Copy B is untouched by faults in copy A, the inverters or the cells (R7 support).
  p_copy_b_r7: assert property (@(posedge clk) disable iff (rst)
    (32'(flt_sel) < B_BASE || 32'(flt_sel) >= 2 * B_BASE) |-> (res_b == gold[W:0]));
endmodule

bind sc_dup_adder sc_dup_adder_chk #(.W(W), .FSEL_W(FSEL_W)) u_chk (
  .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .flt_sel(flt_sel),
  .sum_q(sum_q), .cout_q(cout_q), .err_rail(err_rail), .res_b(res_b));

// File: tb/sc_dup_adder_tb.sv
module sc_dup_adder_tb;
  localparam int W      = 4;
  localparam int FSEL_W = 6;
  localparam int NETS   = 53;
  localparam int A_END  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic cin = 1'b0;
  logic [FSEL_W-1:0] flt_sel = '1;
  logic flt_val = 1'b0;
  logic [W-1:0] sum_q;
  logic cout_q;
  logic [1:0] err_rail;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sc_dup_adder #(.W(W), .FSEL_W(FSEL_W)) u_dut (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .flt_sel(flt_sel),
    .flt_val(flt_val), .sum_q(sum_q), .cout_q(cout_q), .err_rail(err_rail));

  function automatic int exp_sum(int x, int y, int c);
    return x + y + c;
  endfunction

  function automatic bit is_code(logic [1:0] e);
    return e == 2'b01 || e == 2'b10;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Drive at the falling edge, sample just after the next rising edge.
  task automatic apply(int x, int y, int c, int fs, int fv);
    @(negedge clk);
    a = W'(x); b = W'(y); cin = c[0]; flt_sel = FSEL_W'(fs); flt_val = fv[0];
    @(posedge clk);
    #1;
  endtask

  task automatic clean_check(int x, int y, int c, int fs, string tag);
    int got;
    apply(x, y, c, fs, 0);
    got = {27'd0, cout_q, sum_q};
    check(got == exp_sum(x, y, c), {tag, " sum"}, got, exp_sum(x, y, c));
    check(is_code(err_rail), {tag, " code"}, int'(err_rail), 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [NETS-1:0] det0, det1;
    int got;
    det0 = '0; det1 = '0;

    // R1: reset with busy inputs
    rst = 1'b1;
    apply(15, 15, 1, 63, 0);
    apply(9, 3, 1, 63, 0);
    check(sum_q == 0 && cout_q == 0, "R1 result", {cout_q, sum_q}, 0);
    check(err_rail == 2'b01, "R1 pair", int'(err_rail), 1);
    @(negedge clk); rst = 1'b0;

    // R2/R3 directed extremes
    clean_check(0, 0, 0, 63, "R2 zero");
    clean_check(15, 15, 1, 63, "R2 max");
    clean_check(15, 0, 1, 63, "R2 ripple");

    // R2/R3/R6 exhaustive with injection disabled (all ones)
    for (int v = 0; v < 512; v++)
      clean_check(v[3:0], v[7:4], v[8], 63, "R3 R6 sweep");

    // R4/R5/R7 every net, both stuck values, every vector
    for (int f = 0; f < NETS; f++) begin
      for (int sv = 0; sv < 2; sv++) begin
        for (int v = 0; v < 512; v++) begin
          int e;
          apply(v[3:0], v[7:4], v[8], f, sv);
          e = exp_sum(v[3:0], v[7:4], v[8]);
          got = {27'd0, cout_q, sum_q};
          check(got == e || !is_code(err_rail), "R4 silent wrong sum", got, e);
          if (f >= A_END)
            check(got == e, "R7 primary corrupted", got, e);
          if (!is_code(err_rail)) begin
            if (sv == 0) det0[f] = 1'b1; else det1[f] = 1'b1;
          end
        end
      end
      check(det0[f], "R5 stuck0 undetected", f, 1);
      check(det1[f], "R5 stuck1 undetected", f, 1);
    end

    // Seeded random mix, indices across the whole select range
    void'($urandom(32'd7331));
    for (int n = 0; n < 400; n++) begin
      int x, y, c, fs, fv, e;
      x = int'($urandom % 16); y = int'($urandom % 16); c = int'($urandom % 2);
      fs = int'($urandom % 64); fv = int'($urandom % 2);
      apply(x, y, c, fs, fv);
      e = exp_sum(x, y, c);
      got = {27'd0, cout_q, sum_q};
      check(got == e || !is_code(err_rail), "R4 random", got, e);
      if (fs >= NETS) begin
        check(got == e, "R6 out-of-range sum", got, e);
        check(is_code(err_rail), "R6 out-of-range code", int'(err_rail), 1);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule